// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block sits between instruction fetch and execution in a small 32-bit load-store core. Fetch hands it one 16-bit big-endian halfword per handshake, along with that halfword's byte address. The decoder looks at the top bit of each leading halfword to tell the two encoding forms apart. It then pulls out the opcode, the three register fields or the 12-bit immediate, and decides whether a 32-bit literal follows. A literal makes the instruction 48 bits long.

When every halfword of an instruction has arrived, the decoder presents one record to the execution stage. The record holds the fields, the literal, the length in bytes and the address of the next sequential instruction. Opcodes missing from the decode table are not dropped. They are delivered as short instructions with an illegal flag, so that execution can raise a trap.

Top module: `vldec_top`

## Requirements
- R1: A leading halfword with bit 15 = 0 is form 1. Its fields are: out_opcode = bits 14:9, out_ra = bits 8:6, out_rb = bits 5:3, out_rc = bits 2:0. out_form2 = 0 and out_imm12 = 0.
- R2: A leading halfword with bit 15 = 1 is form 2. Its fields are: out_opcode = {000, bits 14:12} and out_imm12 = bits 11:0. out_form2 = 1, and all three register outputs read 0.
- R3: Form 1 opcodes 0 (load immediate) and 2 (absolute call) take a 32-bit literal from the next two halfwords. The first of those halfwords is bits 31:16 of out_literal. out_len = 6. Example: 0x0040, 0x0000, 0x0555 gives opcode 0, ra = 1 and literal 0x00000555.
- R4: Form 1 opcode 3 (return) is legal and 16 bits long: out_len = 2 and out_literal = 0. The halfword after it is decoded as a new instruction.
- R5: Every other form 1 opcode, including 4 (the bad instruction), and every form 2 opcode gives out_illegal = 1, out_len = 2 and out_literal = 0. No trailing halfword is consumed. Legal instructions give out_illegal = 0.
- R6: A record appears on the output only after the last halfword of its instruction has been accepted. Records leave in the order their instructions arrived, with none lost or repeated.
- R7: out_next_pc equals the address given with the leading halfword plus out_len, modulo 2^32.
- R8: While out_valid = 1 and out_ready = 0, the whole output record stays unchanged.
- R9: With in_valid and out_ready held at 1, in_ready stays at 1 every cycle. One record completes per short instruction per cycle.
- R10: After synchronous reset, out_valid = 0, in_ready = 1, and the next accepted halfword is treated as a leading halfword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Fetch offers a halfword |
| in_ready | output | 1 | Decoder accepts the offered halfword |
| in_half | input | 16 | Instruction halfword |
| in_pc | input | 32 | Byte address of the offered halfword |
| out_valid | output | 1 | Decoded record available |
| out_ready | input | 1 | Execution stage takes the record |
| out_form2 | output | 1 | 1 for form 2, 0 for form 1 |
| out_opcode | output | 6 | Opcode (form 2 zero-extended) |
| out_ra | output | 3 | Operand A register field |
| out_rb | output | 3 | Operand B register field |
| out_rc | output | 3 | Operand C register field |
| out_imm12 | output | 12 | Form 2 immediate |
| out_literal | output | 32 | Trailing 32-bit literal, 0 if none |
| out_len | output | 3 | Instruction length in bytes (2 or 6) |
| out_next_pc | output | 32 | Address of next sequential instruction |
| out_illegal | output | 1 | Undefined opcode, trap request |

## Verification
The decoder can finish a new instruction in the same cycle that the execution stage takes the previous record. The two events share the single output register. The bench sets this up by holding in_valid and out_ready high through a long stream of short and literal-carrying instructions. It also uses random valid/ready patterns that often make the two handshakes coincide. The result is judged by comparing every delivered record, in order, with the value a bench model computes from the halfword stream. Any dropped, repeated or overwritten record shows up as a mismatch or as a count error.

// File: rtl/vldec_pkg.sv
// Shared widths and record types for the variable-length decoder.
// Assumes 16-bit halfwords and 32-bit addresses/literals.
package vldec_pkg;
    localparam int HALF_W  = 16;
    localparam int WORD_W  = 32;
    localparam int OP1_W   = 6;
    localparam int OP2_W   = 3;
    localparam int REG_W   = 3;
    localparam int IMM_W   = 12;
    localparam int LEN_W   = 3;
    localparam logic [LEN_W-1:0] LEN_SHORT = 3'd2;
    localparam logic [LEN_W-1:0] LEN_LONG  = 3'd6;

    // Fields recovered from a leading halfword
    typedef struct packed {
        logic             form2;
        logic [OP1_W-1:0] opcode;
        logic [REG_W-1:0] ra;
        logic [REG_W-1:0] rb;
        logic [REG_W-1:0] rc;
        logic [IMM_W-1:0] imm12;
        logic             has_lit;
        logic             illegal;
    } head_t;

    // Complete record handed to execution
    typedef struct packed {
        head_t             head;
        logic [WORD_W-1:0] literal;
        logic [LEN_W-1:0]  len;
        logic [WORD_W-1:0] next_pc;
    } rec_t;
endpackage

// File: rtl/vldec_fields.sv
// Combinational field splitter for a leading halfword.
// Bit 15 picks the form. The legality and literal tables are parameter
// masks indexed by opcode. Assumes the caller only uses the result
// when the halfword really is a leading one.
module vldec_fields
    import vldec_pkg::*;
#(
    parameter logic [63:0] F1_LEGAL = 64'h0000_0000_0000_000D,
    parameter logic [63:0] F1_LIT   = 64'h0000_0000_0000_0005,
    parameter logic [7:0]  F2_LEGAL = 8'h00
) (
    input  logic [HALF_W-1:0] half,
    output head_t             head
);
    logic [OP1_W-1:0] op1;
    logic [OP2_W-1:0] op2;
    logic             legal;

    assign op1 = half[14:9];
    assign op2 = half[14:12];

    // Split fields by form and look up legality / literal need
    always_comb begin
        head       = '0;
        head.form2 = half[15];
        if (!half[15]) begin
            legal        = F1_LEGAL[op1];
            head.opcode  = op1;
            head.ra      = half[8:6];
            head.rb      = half[5:3];
            head.rc      = half[2:0];
            head.has_lit = legal & F1_LIT[op1];
        end else begin
            legal        = F2_LEGAL[op2];
            head.opcode  = {{(OP1_W-OP2_W){1'b0}}, op2};
            head.imm12   = half[IMM_W-1:0];
        end
        head.illegal = !legal;
    end
endmodule

// File: rtl/vldec_collect.sv
// Halfword collector. It holds the leading halfword's fields and address
// while the two literal halfwords arrive, then builds one record.
// Assumes slot_free says whether the output register can take a record
// at this edge.
module vldec_collect
    import vldec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [HALF_W-1:0] in_half,
    input  logic [WORD_W-1:0] in_pc,
    input  head_t             head_in,
    input  logic              slot_free,
    output logic              load,
    output rec_t              rec
);
    typedef enum logic [1:0] {ST_HEAD, ST_LHI, ST_LLO} cstate_t;

    cstate_t           state;
    head_t             head_q;
    logic [WORD_W-1:0] pc_q;
    logic [HALF_W-1:0] hi_q;
    logic              fire;

    // The upper literal halfword never produces output, so it needs no free slot
    assign in_ready = (state == ST_LHI) ? 1'b1 : slot_free;
    assign fire     = in_valid && in_ready;
    assign load     = fire && ((state == ST_HEAD && !head_in.has_lit) || state == ST_LLO);

    // Sequence through leading halfword and literal halves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_HEAD;
            head_q <= '0;
            pc_q   <= '0;
            hi_q   <= '0;
        end else if (fire) begin
            unique case (state)
                ST_HEAD: if (head_in.has_lit) begin
                    head_q <= head_in;
                    pc_q   <= in_pc;
                    state  <= ST_LHI;
                end
                ST_LHI: begin
                    hi_q  <= in_half;
                    state <= ST_LLO;
                end
                default: state <= ST_HEAD;
            endcase
        end
    end

    // Assemble the outgoing record for a short or completed long instruction
    always_comb begin
        if (state == ST_HEAD) begin
            rec.head    = head_in;
            rec.literal = '0;
            rec.len     = LEN_SHORT;
            rec.next_pc = in_pc + WORD_W'(LEN_SHORT);
        end else begin
            rec.head    = head_q;
            rec.literal = {hi_q, in_half};
            rec.len     = LEN_LONG;
            rec.next_pc = pc_q + WORD_W'(LEN_LONG);
        end
    end

    a_r5_illegal_is_short: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HEAD && fire && head_in.illegal) |-> load);
    a_r3_literal_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HEAD && fire && head_in.has_lit) |=> (state == ST_LHI));
    a_r6_no_early_record: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LHI) |-> !load);
endmodule

// File: rtl/vldec_outreg.sv
// Output holding register. It keeps a record until the execution stage
// takes it, and can take a new record in the same cycle it hands one off.
module vldec_outreg
    import vldec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  rec_t rec_in,
    input  logic out_ready,
    output logic out_valid,
    output logic slot_free,
    output rec_t rec_q
);
    assign slot_free = !out_valid || out_ready;

    // Capture a new record or retire the held one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            rec_q     <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            rec_q     <= rec_in;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(rec_q)));
    a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> slot_free);
endmodule

// File: rtl/vldec_top.sv
// Variable-length instruction decoder top. Takes big-endian halfwords
// with valid/ready and emits one decoded record per 16- or 48-bit
// instruction. Assumes in_pc is the byte address of each offered halfword.
module vldec_top
    import vldec_pkg::*;
#(
    parameter logic [63:0] F1_LEGAL = 64'h0000_0000_0000_000D,
    parameter logic [63:0] F1_LIT   = 64'h0000_0000_0000_0005,
    parameter logic [7:0]  F2_LEGAL = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [15:0] in_half,
    input  logic [31:0] in_pc,
    output logic        out_valid,
    input  logic        out_ready,
    output logic        out_form2,
    output logic [5:0]  out_opcode,
    output logic [2:0]  out_ra,
    output logic [2:0]  out_rb,
    output logic [2:0]  out_rc,
    output logic [11:0] out_imm12,
    output logic [31:0] out_literal,
    output logic [2:0]  out_len,
    output logic [31:0] out_next_pc,
    output logic        out_illegal
);
    head_t head_w;
    rec_t  rec_w;
    rec_t  rec_q;
    logic  load_w;
    logic  slot_free_w;

    vldec_fields #(.F1_LEGAL(F1_LEGAL), .F1_LIT(F1_LIT), .F2_LEGAL(F2_LEGAL)) u_fields (
        .half (in_half),
        .head (head_w)
    );

    vldec_collect u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_half   (in_half),
        .in_pc     (in_pc),
        .head_in   (head_w),
        .slot_free (slot_free_w),
        .load      (load_w),
        .rec       (rec_w)
    );

    vldec_outreg u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_w),
        .rec_in    (rec_w),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .slot_free (slot_free_w),
        .rec_q     (rec_q)
    );

    assign out_form2   = rec_q.head.form2;
    assign out_opcode  = rec_q.head.opcode;
    assign out_ra      = rec_q.head.ra;
    assign out_rb      = rec_q.head.rb;
    assign out_rc      = rec_q.head.rc;
    assign out_imm12   = rec_q.head.imm12;
    assign out_literal = rec_q.literal;
    assign out_len     = rec_q.len;
    assign out_next_pc = rec_q.next_pc;
    assign out_illegal = rec_q.head.illegal;

    a_r7_len_values: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len == LEN_SHORT || out_len == LEN_LONG));
    a_r2_form2_short: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_form2) |-> (out_len == LEN_SHORT && out_literal == '0));
    a_r5_long_is_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_len == LEN_LONG) |-> !out_illegal);
    a_r10_reset_empty: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

// File: tb/sim_vldec_top.sv
module sim_vldec_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_half = '0;
    logic [31:0] in_pc = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        out_form2;
    logic [5:0]  out_opcode;
    logic [2:0]  out_ra, out_rb, out_rc;
    logic [11:0] out_imm12;
    logic [31:0] out_literal;
    logic [2:0]  out_len;
    logic [31:0] out_next_pc;
    logic        out_illegal;

    int errors = 0;
    int checks = 0;

    logic [15:0] hw_q[$];
    logic [31:0] hpc_q[$];
    bit          last_q[$];
    logic [15:0] exp_h[$];
    logic [31:0] exp_l[$];
    logic [31:0] exp_p[$];
    int drv_idx = 0;
    int completed = 0;
    int popped = 0;

    always #10 clk = ~clk;

    vldec_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_half(in_half), .in_pc(in_pc), .out_valid(out_valid), .out_ready(out_ready),
        .out_form2(out_form2), .out_opcode(out_opcode), .out_ra(out_ra), .out_rb(out_rb),
        .out_rc(out_rc), .out_imm12(out_imm12), .out_literal(out_literal), .out_len(out_len),
        .out_next_pc(out_next_pc), .out_illegal(out_illegal)
    );

    logic [95:0] out_bus;
    assign out_bus = {out_form2, out_opcode, out_ra, out_rb, out_rc, out_imm12,
                      out_literal, out_len, out_next_pc, out_illegal};

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Bench model of the decode table
    function automatic bit m_legal(input logic [15:0] h);
        if (h[15]) return 1'b0;
        return (h[14:9] == 6'd0) || (h[14:9] == 6'd2) || (h[14:9] == 6'd3);
    endfunction
    function automatic bit m_lit(input logic [15:0] h);
        return !h[15] && ((h[14:9] == 6'd0) || (h[14:9] == 6'd2));
    endfunction

    task automatic add_insn(input logic [15:0] h, input logic [31:0] lit, input logic [31:0] pc);
        bit l = m_lit(h);
        hw_q.push_back(h); hpc_q.push_back(pc); last_q.push_back(!l);
        if (l) begin
            hw_q.push_back(lit[31:16]); hpc_q.push_back(pc + 32'd2); last_q.push_back(1'b0);
            hw_q.push_back(lit[15:0]);  hpc_q.push_back(pc + 32'd4); last_q.push_back(1'b1);
        end
        exp_h.push_back(h); exp_l.push_back(l ? lit : 32'd0); exp_p.push_back(pc);
    endtask

    task automatic compare_record();
        logic [15:0] h = exp_h.pop_front();
        logic [31:0] l = exp_l.pop_front();
        logic [31:0] p = exp_p.pop_front();
        logic [2:0]  len = m_lit(h) ? 3'd6 : 3'd2;
        check(popped < completed, "R6 record before last halfword", popped, completed);
        popped++;
        check(out_form2 == h[15], "R1/R2 form bit", out_form2, h[15]);
        if (!h[15]) begin
            check(out_opcode == h[14:9], "R1 opcode", out_opcode, h[14:9]);
            check({out_ra, out_rb, out_rc} == h[8:0], "R1 register fields", {out_ra, out_rb, out_rc}, h[8:0]);
            check(out_imm12 == 12'd0, "R1 imm zero", out_imm12, 0);
        end else begin
            check(out_opcode == {3'b000, h[14:12]}, "R2 opcode", out_opcode, h[14:12]);
            check(out_imm12 == h[11:0], "R2 imm12", out_imm12, h[11:0]);
            check({out_ra, out_rb, out_rc} == 9'd0, "R2 registers zero", {out_ra, out_rb, out_rc}, 0);
        end
        check(out_literal == l, "R3/R4 literal", out_literal, l);
        check(out_len == len, "R3/R4/R5 length", out_len, len);
        check(out_illegal == !m_legal(h), "R5 illegal flag", out_illegal, !m_legal(h));
        check(out_next_pc == p + 32'(len), "R7 next pc", out_next_pc, p + 32'(len));
    endtask

    task automatic run_phase(input int pv, input int pr, input bit b2b);
        int guard = 0;
        bit stalled = 1'b0;
        logic [95:0] snap = '0;
        while ((drv_idx < hw_q.size() || exp_h.size() > 0) && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (stalled)
                check(out_valid && out_bus == snap, "R8 record held while stalled", out_bus[31:0], snap[31:0]);
            in_valid = (drv_idx < hw_q.size()) && ($urandom_range(99) < pv);
            if (drv_idx < hw_q.size()) begin
                in_half = hw_q[drv_idx];
                in_pc   = hpc_q[drv_idx];
            end
            out_ready = ($urandom_range(99) < pr);
            #1;
            if (b2b && in_valid) check(in_ready, "R9 back-to-back in_ready", in_ready, 1);
            if (out_valid && out_ready) compare_record();
            stalled = out_valid && !out_ready;
            snap = out_bus;
            if (in_valid && in_ready) begin
                if (last_q[drv_idx]) completed++;
                drv_idx++;
            end
        end
        if (guard >= 20000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", guard, 20000);
        end
        in_valid = 1'b0;
        hw_q.delete(); hpc_q.delete(); last_q.delete();
        drv_idx = 0; completed = 0; popped = 0;
    endtask

    initial begin
        logic [31:0] pc;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(!out_valid, "R10 out_valid after reset", out_valid, 0);
        check(in_ready, "R10 in_ready after reset", in_ready, 1);

        // Directed corner cases
        add_insn(16'h0040, 32'h0000_0555, 32'h0000_1054);   // R3 load immediate into field 1
        add_insn(16'h0400, 32'h0000_108A, 32'h0000_105A);   // R3 call
        add_insn(16'h0600, 32'h0, 32'h0000_1060);           // R4 return
        add_insn(16'h0800, 32'h0, 32'h0000_1062);           // R5 bad
        add_insn(16'h8ABC, 32'h0, 32'h0000_1064);           // R2/R5 form 2
        add_insn(16'h7FFF, 32'h0, 32'h0000_1066);           // R5 opcode 63
        add_insn(16'h0040, 32'hDEAD_BEEF, 32'hFFFF_FFFC);   // R7 wrap
        add_insn(16'h0600, 32'h0, 32'h0000_0002);
        run_phase(100, 100, 1'b0);

        // Random mix with random handshakes
        pc = 32'h0000_2000;
        for (int i = 0; i < 300; i++) begin
            logic [15:0] h;
            if ($urandom_range(1) == 0) begin
                logic [5:0] op;
                case ($urandom_range(3))
                    0: op = 6'd0;
                    1: op = 6'd2;
                    2: op = 6'd3;
                    default: op = 6'd4;
                endcase
                h = {1'b0, op, 9'($urandom)};
            end else begin
                h = 16'($urandom);
            end
            if ($urandom_range(15) == 0) pc = {$urandom} & 32'hFFFF_FFFE;
            add_insn(h, $urandom, pc);
            pc = pc + (m_lit(h) ? 32'd6 : 32'd2);
        end
        run_phase(70, 60, 1'b0);

        // R9 back-to-back stream with completion and hand-off coinciding
        pc = 32'h0000_8000;
        for (int i = 0; i < 60; i++) begin
            logic [15:0] h = (i % 3 == 0) ? 16'h0440 : {1'b0, 6'd3, 9'($urandom)};
            add_insn(h, $urandom, pc);
            pc = pc + (m_lit(h) ? 32'd6 : 32'd2);
        end
        run_phase(100, 100, 1'b1);

        // R10 reset in mid literal: next halfword is a leading one
        add_insn(16'h0040, 32'h1234_5678, 32'h0);
        in_valid = 1'b1; in_half = 16'h0040; in_pc = 32'h0; out_ready = 1'b1;
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        hw_q.delete(); hpc_q.delete(); last_q.delete();
        exp_h.delete(); exp_l.delete(); exp_p.delete();
        add_insn(16'h0600, 32'h0, 32'h0000_0100);
        run_phase(100, 100, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule